// File: doc/BRIEF.md
# Trap Entry and Vector Unit

This block performs the entry half of trap handling for a 64-bit processor that supports nested trap levels and an optional hypervisor privilege layer. A one-cycle strobe brings a 9-bit trap type together with the PC and NPC of the interrupted instruction. On the next clock edge the block pushes a context entry onto a per-level trap-state stack and raises the trap level. It rewrites the processor-state and hyperprivileged-state registers according to the class of the trap. For fill traps it steps the window pointer. It also loads the new PC and NPC with the trap vector.

The vector comes from one of two base registers. The hypervisor base is used when the hypervisor layer is present and the updated hyperprivileged bit is set. The normal base is used otherwise, and the normal vector adds a nesting-level bit. A `hyp_present` input selects the hypervisor rule set at run time. The entry at the current trap level is visible on the `top_*` outputs, so the pipeline and the trap-return logic can read the saved context.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, tl=0, pstate=0x004, hpstate=0x00, cwp=0, pc=0, npc=0, entry_done=0, and all top_* outputs read 0.
- R2: The state updates on the clock edge that samples trap_valid high, and entry_done is high for exactly the following cycle. tl becomes tl+1, saturating at MAX_TL (default 6). The stack entry at the new level stores trap_pc, trap_npc and trap_type, and the top_* outputs always show the entry at the current tl. A cycle without trap_valid changes no state.
- R3: With hyp_present=1, the old hpstate is stored in the new entry (top_htstate). If the new tl is greater than 2, hpstate bit 2 (hyperprivileged) is set.
- R4: Trap types 0x008, 0x030 and 0x064–0x06F form the MMU class. With hyp_present=1 they set hpstate bit 2 and write pstate=0x014. Without it they write pstate=0x414. The pstate bit positions are AG=0, PRIV=2, PEF=4, MG=10 and IG=11.
- R5: Trap type 0x060 (interrupt vector) writes pstate=0x814 when hyp_present=0, and leaves pstate unchanged when hyp_present=1.
- R6: Trap types 0x03E, 0x03F and 0x180–0x1FF set hpstate bit 2 and leave pstate unchanged.
- R7: Every other trap type, including ordinary trap instructions 0x100–0x17F, writes pstate=0x015.
- R8: When hyp_present=1 and the updated hpstate bit 2 is 1, pc = {htba[63:14], 14'b0} | (trap_type << 5).
- R9: Otherwise pc = {tba[63:15], 15'b0} | ((new tl > 1) << 14) | (trap_type << 5).
- R10: After each trap entry, npc = pc + 4.
- R11: When trap_type[8:6] = 3'b011 (fill class), cwp advances by one modulo NWIN (default 8). For every other type, cwp is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | One-cycle trap request strobe |
| trap_type | input | 9 | Trap type code |
| trap_pc | input | 64 | PC of the interrupted instruction |
| trap_npc | input | 64 | NPC of the interrupted instruction |
| hyp_present | input | 1 | Hypervisor layer present |
| tba | input | 64 | Normal trap base address |
| htba | input | 64 | Hypervisor trap base address |
| pc | output | 64 | New program counter |
| npc | output | 64 | New next program counter |
| tl | output | 3 | Current trap level |
| pstate | output | 12 | Processor state |
| hpstate | output | 8 | Hyperprivileged state |
| cwp | output | 3 | Current window pointer |
| top_pc | output | 64 | Saved PC at current level |
| top_npc | output | 64 | Saved NPC at current level |
| top_tt | output | 9 | Saved trap type at current level |
| top_htstate | output | 8 | Saved hpstate at current level |
| entry_done | output | 1 | Trap entry completed pulse |

## Verification
Chains of traps are taken from reset, both without and with the hypervisor layer. The same trap types are reused at different depths, which separates the level bit of the normal vector from the depth rule that forces the hyperprivileged bit. The edges of the MMU class, the interrupt vector, real-translation misses and the hypervisor trap range (0x180 and 0x1FF) are each compared with a neighbouring default-class code. This shows which rule set fired and which base register formed the vector. A run of eight fill traps tests window wraparound and trap-level saturation, and a spill-class code checks that cwp stays put.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    localparam int PS_W = 12;
    localparam int HS_W = 8;
    localparam int TT_W = 9;
    localparam int XLEN = 64;

    // processor-state bit positions
    localparam int PS_AG   = 0;
    localparam int PS_PRIV = 2;
    localparam int PS_PEF  = 4;
    localparam int PS_MG   = 10;
    localparam int PS_IG   = 11;
    // hyperprivileged-state bit position
    localparam int HS_HPRIV = 2;

    localparam logic [PS_W-1:0] PS_RESET = PS_W'(1) << PS_PRIV;
    localparam logic [PS_W-1:0] PS_BASE  = (PS_W'(1) << PS_PEF) | (PS_W'(1) << PS_PRIV);

    // trap type codes
    localparam logic [TT_W-1:0] TT_IFAULT   = 9'h008;
    localparam logic [TT_W-1:0] TT_DFAULT_C = 9'h030;
    localparam logic [TT_W-1:0] TT_RMISS_LO = 9'h03E;
    localparam logic [TT_W-1:0] TT_RMISS_HI = 9'h03F;
    localparam logic [TT_W-1:0] TT_INTVEC   = 9'h060;
    localparam logic [TT_W-1:0] TT_MMUGRP_LO = 9'h064;
    localparam logic [TT_W-1:0] TT_MMUGRP_HI = 9'h06F;
    localparam logic [TT_W-1:0] TT_HYPER_LO = 9'h180;
    localparam logic [2:0]      TT_FILL_GRP = 3'b011;

    typedef enum logic [1:0] {
        CLS_INTVEC,
        CLS_MMU,
        CLS_HYPER,
        CLS_OTHER
    } trap_class_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic [TT_W-1:0] tt;
        logic [HS_W-1:0] hts;
    } ts_entry_t;

endpackage

// File: rtl/trap_classifier.sv
module trap_classifier
    import trap_entry_pkg::*;
(
    input  logic [TT_W-1:0] tt,
    output trap_class_e     cls,
    output logic            is_fill
);

    logic in_mmu_grp;
    logic in_rmiss;
    logic in_hyper;

    always_comb begin
        in_mmu_grp = (tt >= TT_MMUGRP_LO) && (tt <= TT_MMUGRP_HI);
        in_rmiss   = (tt >= TT_RMISS_LO) && (tt <= TT_RMISS_HI);
        in_hyper   = (tt >= TT_HYPER_LO);
        is_fill    = (tt[8:6] == TT_FILL_GRP);

        if (tt == TT_INTVEC) begin
            cls = CLS_INTVEC;
        end else if (in_mmu_grp || tt == TT_IFAULT || tt == TT_DFAULT_C) begin
            cls = CLS_MMU;
        end else if (in_rmiss || in_hyper) begin
            cls = CLS_HYPER;
        end else begin
            cls = CLS_OTHER;
        end
    end

endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
    import trap_entry_pkg::*;
#(
    parameter int TL_W = 3
) (
    input  logic [TT_W-1:0] tt,
    input  logic [XLEN-1:0] tba,
    input  logic [XLEN-1:0] htba,
    input  logic            hyp_mode,
    input  logic [TL_W-1:0] new_tl,
    output logic [XLEN-1:0] vec_pc,
    output logic [XLEN-1:0] vec_npc
);

    localparam logic [TL_W-1:0] ONE_L = TL_W'(1);

    logic [XLEN-1:0] tt_off;
    logic            nest_bit;

    always_comb begin
        tt_off   = {{(XLEN-TT_W-5){1'b0}}, tt, 5'b0};
        nest_bit = (new_tl > ONE_L);
        if (hyp_mode) begin
            vec_pc = {htba[XLEN-1:14], 14'b0} | tt_off;
        end else begin
            vec_pc = {tba[XLEN-1:15], nest_bit, 14'b0} | tt_off;
        end
        vec_npc = vec_pc + XLEN'(4);
    end

endmodule

// File: rtl/trap_state_stack.sv
module trap_state_stack
    import trap_entry_pkg::*;
#(
    parameter int MAX_TL = 6,
    parameter int TL_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [TL_W-1:0] wr_lvl,
    input  ts_entry_t       wr_data,
    input  logic [TL_W-1:0] rd_lvl,
    output ts_entry_t       rd_data
);

    ts_entry_t slot [MAX_TL];

    for (genvar g = 0; g < MAX_TL; g++) begin : g_level
        ts_entry_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && wr_lvl == TL_W'(g + 1)) begin
                ent_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign slot[g] = ent_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < MAX_TL; i++) begin
            if (rd_lvl == TL_W'(i + 1)) begin
                rd_data = slot[i];
            end
        end
    end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int MAX_TL      = 6,
    parameter int MAX_PRIV_TL = 2,
    parameter int NWIN        = 8,
    localparam int TL_W  = $clog2(MAX_TL + 1),
    localparam int CWP_W = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_valid,
    input  logic [TT_W-1:0]   trap_type,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_npc,
    input  logic              hyp_present,
    input  logic [XLEN-1:0]   tba,
    input  logic [XLEN-1:0]   htba,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   npc,
    output logic [TL_W-1:0]   tl,
    output logic [PS_W-1:0]   pstate,
    output logic [HS_W-1:0]   hpstate,
    output logic [CWP_W-1:0]  cwp,
    output logic [XLEN-1:0]   top_pc,
    output logic [XLEN-1:0]   top_npc,
    output logic [TT_W-1:0]   top_tt,
    output logic [HS_W-1:0]   top_htstate,
    output logic              entry_done
);

    localparam logic [TL_W-1:0]  TL_MAX_L  = TL_W'(MAX_TL);
    localparam logic [TL_W-1:0]  TL_PRIV_L = TL_W'(MAX_PRIV_TL);
    localparam logic [CWP_W-1:0] CWP_LAST  = CWP_W'(NWIN - 1);

    typedef struct packed {
        logic [XLEN-1:0]  pc;
        logic [XLEN-1:0]  npc;
        logic [TL_W-1:0]  tl;
        logic [PS_W-1:0]  ps;
        logic [HS_W-1:0]  hs;
        logic [CWP_W-1:0] cwp;
        logic             done;
    } core_state_t;

    core_state_t st_d, st_q;

    trap_class_e     cls;
    logic            is_fill;
    logic [TL_W-1:0] tl_next;
    logic [HS_W-1:0] hs_next;
    logic            hyp_mode;
    logic [XLEN-1:0] vec_pc, vec_npc;
    ts_entry_t       push_entry;
    ts_entry_t       top_entry;

    trap_classifier u_classify (
        .tt      (trap_type),
        .cls     (cls),
        .is_fill (is_fill)
    );

    // trap level and hyperprivileged state ahead of the vector choice
    always_comb begin
        tl_next = (st_q.tl == TL_MAX_L) ? TL_MAX_L : st_q.tl + TL_W'(1);
        hs_next = st_q.hs;
        if (hyp_present && tl_next > TL_PRIV_L) begin
            hs_next[HS_HPRIV] = 1'b1;
        end
        if (cls == CLS_HYPER) begin
            hs_next[HS_HPRIV] = 1'b1;
        end
        if (cls == CLS_MMU && hyp_present) begin
            hs_next[HS_HPRIV] = 1'b1;
        end
        hyp_mode = hyp_present && hs_next[HS_HPRIV];
    end

    trap_vector_gen #(.TL_W(TL_W)) u_vector (
        .tt       (trap_type),
        .tba      (tba),
        .htba     (htba),
        .hyp_mode (hyp_mode),
        .new_tl   (tl_next),
        .vec_pc   (vec_pc),
        .vec_npc  (vec_npc)
    );

    always_comb begin
        push_entry.pc  = trap_pc;
        push_entry.npc = trap_npc;
        push_entry.tt  = trap_type;
        push_entry.hts = hyp_present ? st_q.hs : '0;
    end

    trap_state_stack #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (trap_valid),
        .wr_lvl  (tl_next),
        .wr_data (push_entry),
        .rd_lvl  (st_q.tl),
        .rd_data (top_entry)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (trap_valid) begin
            st_d.done = 1'b1;
            st_d.tl   = tl_next;
            st_d.hs   = hs_next;
            st_d.pc   = vec_pc;
            st_d.npc  = vec_npc;
            unique case (cls)
                CLS_INTVEC: begin
                    if (!hyp_present) begin
                        st_d.ps = PS_BASE | (PS_W'(1) << PS_IG);
                    end
                end
                CLS_MMU: begin
                    if (hyp_present) begin
                        st_d.ps = PS_BASE;
                    end else begin
                        st_d.ps = PS_BASE | (PS_W'(1) << PS_MG);
                    end
                end
                CLS_HYPER: begin
                    st_d.ps = st_q.ps;
                end
                default: begin
                    st_d.ps = PS_BASE | (PS_W'(1) << PS_AG);
                end
            endcase
            if (is_fill) begin
                st_d.cwp = (st_q.cwp == CWP_LAST) ? '0 : st_q.cwp + CWP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ps   <= PS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc          = st_q.pc;
    assign npc         = st_q.npc;
    assign tl          = st_q.tl;
    assign pstate      = st_q.ps;
    assign hpstate     = st_q.hs;
    assign cwp         = st_q.cwp;
    assign entry_done  = st_q.done;
    assign top_pc      = top_entry.pc;
    assign top_npc     = top_entry.npc;
    assign top_tt      = top_entry.tt;
    assign top_htstate = top_entry.hts;

endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker #(
    parameter int MAX_TL      = 6,
    parameter int MAX_PRIV_TL = 2,
    parameter int TL_W        = 3,
    parameter int CWP_W       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trap_valid,
    input logic [8:0]       trap_type,
    input logic             hyp_present,
    input logic [63:0]      pc,
    input logic [63:0]      npc,
    input logic [TL_W-1:0]  tl,
    input logic [11:0]      pstate,
    input logic [7:0]       hpstate,
    input logic [CWP_W-1:0] cwp,
    input logic [8:0]       top_tt,
    input logic             entry_done
);

    localparam logic [TL_W-1:0] TL_MAX_L  = TL_W'(MAX_TL);
    localparam logic [TL_W-1:0] TL_PRIV_L = TL_W'(MAX_PRIV_TL);

    assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> entry_done);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> !entry_done);

    assert_quiet_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> ($stable(tl) && $stable(pstate) && $stable(hpstate) && $stable(cwp)));

    assert_tl_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && tl < TL_MAX_L) |=> (tl == $past(tl) + TL_W'(1)));

    assert_saved_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (top_tt == $past(trap_type)));

    assert_deep_hpriv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && hyp_present && tl >= TL_PRIV_L) |=> hpstate[2]);

    assert_vec_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (pc[4:0] == 5'd0));

    assert_npc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (npc == pc + 64'd4));

    assert_cwp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_type[8:6] != 3'b011) |=> $stable(cwp));

endmodule

bind trap_entry_unit trap_entry_checker #(
    .MAX_TL      (MAX_TL),
    .MAX_PRIV_TL (MAX_PRIV_TL),
    .TL_W        (TL_W),
    .CWP_W       (CWP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_valid  (trap_valid),
    .trap_type   (trap_type),
    .hyp_present (hyp_present),
    .pc          (pc),
    .npc         (npc),
    .tl          (tl),
    .pstate      (pstate),
    .hpstate     (hpstate),
    .cwp         (cwp),
    .top_tt      (top_tt),
    .entry_done  (entry_done)
);

// File: tb/trap_entry_unit_bench.sv
module trap_entry_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid = 1'b0;
    logic [8:0]  trap_type = '0;
    logic [63:0] trap_pc = '0;
    logic [63:0] trap_npc = '0;
    logic        hyp_present = 1'b0;
    logic [63:0] tba  = 64'h0000_1234_5678_FFFF;
    logic [63:0] htba = 64'h0000_0ABC_0000_7FFF;
    logic [63:0] pc, npc, top_pc, top_npc;
    logic [2:0]  tl, cwp;
    logic [11:0] pstate;
    logic [7:0]  hpstate, top_htstate;
    logic [8:0]  top_tt;
    logic        entry_done;

    int checks = 0;
    int failures = 0;
    int seq = 0;

    localparam logic [63:0] NBASE = 64'h0000_1234_5678_8000;
    localparam logic [63:0] HBASE = 64'h0000_0ABC_0000_4000;

    trap_entry_unit u_trap_entry_unit (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_type(trap_type),
        .trap_pc(trap_pc), .trap_npc(trap_npc), .hyp_present(hyp_present),
        .tba(tba), .htba(htba), .pc(pc), .npc(npc), .tl(tl), .pstate(pstate),
        .hpstate(hpstate), .cwp(cwp), .top_pc(top_pc), .top_npc(top_npc),
        .top_tt(top_tt), .top_htstate(top_htstate), .entry_done(entry_done)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic hyp);
        @(negedge clk);
        rst_n = 1'b0;
        hyp_present = hyp;
        trap_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // strobe one trap; returns at the negedge after the capturing edge
    task automatic fire(input logic [8:0] tt);
        @(negedge clk);
        seq++;
        trap_type  = tt;
        trap_pc    = 64'h0000_0000_0040_0000 + 64'(seq * 8);
        trap_npc   = trap_pc + 64'd4;
        trap_valid = 1'b1;
        @(negedge clk);
        trap_valid = 1'b0;
    endtask

    task automatic entry_ok(input string req, input logic [63:0] exp_pc,
                            input logic [11:0] exp_ps, input logic [7:0] exp_hs,
                            input logic [2:0] exp_tl);
        chk(req, "pc", pc, exp_pc);
        chk("R10", "npc", npc, exp_pc + 64'd4);
        chk(req, "pstate", 64'(pstate), 64'(exp_ps));
        chk(req, "hpstate", 64'(hpstate), 64'(exp_hs));
        chk("R2", "tl", 64'(tl), 64'(exp_tl));
        chk("R2", "entry_done", 64'(entry_done), 64'd1);
        chk("R2", "top_pc", top_pc, trap_pc);
        chk("R2", "top_npc", top_npc, trap_npc);
        chk("R2", "top_tt", 64'(top_tt), 64'(trap_type));
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1", "tl", 64'(tl), 64'd0);
        chk("R1", "pstate", 64'(pstate), 64'h004);
        chk("R1", "hpstate", 64'(hpstate), 64'h00);
        chk("R1", "cwp", 64'(cwp), 64'd0);
        chk("R1", "pc", pc, 64'd0);
        chk("R1", "npc", npc, 64'd0);
        chk("R1", "entry_done", 64'(entry_done), 64'd0);
        chk("R1", "top_pc", top_pc, 64'd0);
        chk("R1", "top_tt", 64'(top_tt), 64'd0);
    endtask

    task automatic t_plain_chain();
        do_reset(1'b0);
        fire(9'h041);
        entry_ok("R7", NBASE | 64'h0820, 12'h015, 8'h00, 3'd1);
        @(negedge clk);
        chk("R2", "done drops", 64'(entry_done), 64'd0);
        chk("R2", "tl held", 64'(tl), 64'd1);
        fire(9'h068);
        entry_ok("R4", NBASE | 64'h4D00, 12'h414, 8'h00, 3'd2);
        chk("R9", "nest bit", 64'(pc[14]), 64'd1);
        fire(9'h060);
        entry_ok("R5", NBASE | 64'h4C00, 12'h814, 8'h00, 3'd3);
        fire(9'h06F);
        entry_ok("R4", NBASE | 64'h4DE0, 12'h414, 8'h00, 3'd4);
        fire(9'h070);
        entry_ok("R7", NBASE | 64'h4E00, 12'h015, 8'h00, 3'd5);
        fire(9'h120);
        entry_ok("R7", NBASE | 64'h6400, 12'h015, 8'h00, 3'd6);
    endtask

    task automatic t_fill_wrap();
        do_reset(1'b0);
        for (int i = 1; i <= 8; i++) begin
            fire(9'h0C4);
            chk("R11", "cwp step", 64'(cwp), 64'(i % 8));
        end
        chk("R2", "tl saturates", 64'(tl), 64'd6);
        chk("R2", "top_tt at max", 64'(top_tt), 64'h0C4);
        fire(9'h080);
        chk("R11", "spill keeps cwp", 64'(cwp), 64'd0);
        chk("R2", "tl stays max", 64'(tl), 64'd6);
    endtask

    task automatic t_hyp_classes();
        do_reset(1'b1);
        fire(9'h060);
        entry_ok("R5", NBASE | 64'h0C00, 12'h004, 8'h00, 3'd1);
        chk("R3", "saved hts", 64'(top_htstate), 64'h00);
        fire(9'h030);
        entry_ok("R4", HBASE | 64'h0600, 12'h014, 8'h04, 3'd2);
        chk("R3", "saved hts", 64'(top_htstate), 64'h00);
        fire(9'h041);
        entry_ok("R8", HBASE | 64'h0820, 12'h015, 8'h04, 3'd3);
        chk("R3", "saved hts", 64'(top_htstate), 64'h04);
    endtask

    task automatic t_hyp_depth();
        do_reset(1'b1);
        fire(9'h041);
        entry_ok("R9", NBASE | 64'h0820, 12'h015, 8'h00, 3'd1);
        fire(9'h041);
        entry_ok("R9", NBASE | 64'h4820, 12'h015, 8'h00, 3'd2);
        fire(9'h041);
        entry_ok("R3", HBASE | 64'h0820, 12'h015, 8'h04, 3'd3);
        chk("R3", "saved hts", 64'(top_htstate), 64'h00);
    endtask

    task automatic t_hyper_range();
        do_reset(1'b1);
        fire(9'h180);
        entry_ok("R6", HBASE | 64'h3000, 12'h004, 8'h04, 3'd1);
        fire(9'h03E);
        entry_ok("R6", HBASE | 64'h07C0, 12'h004, 8'h04, 3'd2);
        chk("R3", "saved hts", 64'(top_htstate), 64'h04);
        fire(9'h1FF);
        entry_ok("R8", HBASE | 64'h3FE0, 12'h004, 8'h04, 3'd3);
        do_reset(1'b0);
        fire(9'h180);
        entry_ok("R6", NBASE | 64'h3000, 12'h004, 8'h04, 3'd1);
        chk("R3", "no hyp hts", 64'(top_htstate), 64'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        t_reset();
        t_plain_chain();
        t_fill_wrap();
        t_hyp_classes();
        t_hyp_depth();
        t_hyper_range();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule